// File: doc/BRIEF.md
# Post-Update Shifted-Index Load Address Unit

This unit sequences one floating-point load that uses a scaled index and updates its base register afterwards. A decoded request brings the current base register value, the index register value, a small shift code, a flag saying whether the base register specifier is zero, and a size select (32-bit word or 64-bit doubleword). The unit computes the sum of the base and the index scaled by two to the power (shift code plus one). It does not read memory at that sum. It reads memory at the unmodified base. When the read data returns, it presents two results together: the loaded value for the floating-point target and the new base value for the base register.

A doubleword goes to the target unchanged. A word is not written to the target directly. It is placed, zero-extended, on a separate output whose strobe tells a later stage to convert it from single to double format. A request whose base specifier is zero is an illegal form. It is dropped with a one-cycle invalid pulse, and it causes no memory traffic and no writeback. Only one request is in flight at a time. Every port uses a valid/ready handshake.

Top module: `pul_load_agu`

## Requirements
- R1: The base update value `wb_base_data` equals `req_base + (req_index << (req_shift + 1))`, taken modulo 2^64.
- R2: The memory read address `rd_req_addr` equals the unmodified `req_base`, never the sum.
- R3: When `req_dword` is 0, the read is issued with `rd_req_dword`=0. At writeback, `wb_word_valid`=1 and `wb_fpr_valid`=0. `wb_word_data` holds bits [31:0] of the read data, and bits [63:32] are zero.
- R4: When `req_dword` is 1, the read is issued with `rd_req_dword`=1. At writeback, `wb_fpr_valid`=1 and `wb_word_valid`=0. `wb_fpr_data` equals the 64-bit read data unchanged.
- R5: The base update strobe and the data strobe (`wb_fpr_valid` or `wb_word_valid`) are asserted in the same cycle, and `wb_base_valid` never appears alone.
- R6: A request accepted with `req_base_is_zero`=1 raises `inv_pulse` for exactly the one cycle after acceptance. It produces no read request and no writeback, and `req_ready` stays 1.
- R7: After a legal request is accepted, `req_ready` stays 0 until the writeback handshake (`wb_valid` and `wb_ready`) completes.
- R8: While `rd_req_valid` is held with `rd_req_ready`=0, the address and size stay stable. While `wb_valid` is held with `wb_ready`=0, all writeback data stays stable.
- R9: A cycle with `rst`=1 leaves `rd_req_valid`, `wb_valid` and `inv_pulse` at 0 and `req_ready` at 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_base | input | 64 | Base register value |
| req_index | input | 64 | Index register value |
| req_shift | input | 2 | Shift code; scale is 2^(code+1) |
| req_base_is_zero | input | 1 | Base register specifier is zero (illegal form) |
| req_dword | input | 1 | 1 = doubleword load, 0 = word load |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 64 | Read address (old base) |
| rd_req_dword | output | 1 | Read size, 1 = 8 bytes, 0 = 4 bytes |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Unit accepts read data |
| rd_rsp_data | input | 64 | Read data; a word sits in bits [31:0] |
| wb_valid | output | 1 | Writeback pair valid |
| wb_ready | input | 1 | Register file accepts the pair |
| wb_fpr_valid | output | 1 | Target gets doubleword data |
| wb_fpr_data | output | 64 | Doubleword for the target |
| wb_word_valid | output | 1 | Word awaiting single-to-double conversion |
| wb_word_data | output | 64 | Zero-extended loaded word |
| wb_base_valid | output | 1 | Base register update valid |
| wb_base_data | output | 64 | Updated base value |
| inv_pulse | output | 1 | Illegal-form request was dropped |

## Verification
The load result and the base register update are handed over in the same cycle, and each of them could go wrong on its own. The bench holds `wb_ready` low for zero, one or two cycles, so the pair has to stay presented across a stall. It then samples every writeback output in the one cycle before the handshake and compares the data strobe, the base strobe and both values at once. The expected values are computed in the bench: the sum comes from a shift and an add, and the data comes from the word or doubleword selection. The sweep covers every shift code, both sizes, and base/index patterns that include wrap-around of the sum.

// File: rtl/pul_pkg.sv
package pul_pkg;
   typedef enum logic [1:0] {
      PUL_IDLE      = 2'd0,
      PUL_WAIT_MEM  = 2'd1,
      PUL_WRITEBACK = 2'd2
   } pul_state_e;
endpackage

// File: rtl/pul_ea_gen.sv
module pul_ea_gen #(
   parameter int ADDR_W = 64,
   parameter int SH_W   = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] index,
   input  logic [SH_W-1:0]   shift,
   output logic [ADDR_W-1:0] sum
);
   localparam int AMT_W = SH_W + 1;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("pul_ea_gen: ADDR_W must be at least 8");
   end
   if (SH_W < 1 || SH_W > 5) begin : g_bad_sh
      $error("pul_ea_gen: SH_W must be 1..5");
   end

   // scaled index shift amount is code + 1
   logic [AMT_W-1:0] amt;
   assign amt = {1'b0, shift} + AMT_W'(1);

   logic [ADDR_W-1:0] stage [AMT_W+1];
   assign stage[0] = index;

   for (genvar i = 0; i < AMT_W; i++) begin : g_stage
      assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
   end

   assign sum = base + stage[AMT_W];
endmodule

// File: rtl/pul_ctrl.sv
module pul_ctrl
   import pul_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_valid,
   input  logic req_bad,
   output logic req_ready,
   output logic rd_req_valid,
   input  logic rd_req_ready,
   input  logic rd_rsp_valid,
   output logic rd_rsp_ready,
   output logic wb_valid,
   input  logic wb_ready,
   output logic inv_pulse,
   output logic cap_req,
   output logic cap_rsp
);
   pul_state_e state_q;
   logic       sent_q;
   logic       inv_q;

   assign req_ready    = (state_q == PUL_IDLE);
   assign rd_req_valid = (state_q == PUL_WAIT_MEM) && !sent_q;
   assign rd_rsp_ready = (state_q == PUL_WAIT_MEM) && sent_q;
   assign wb_valid     = (state_q == PUL_WRITEBACK);
   assign inv_pulse    = inv_q;
   assign cap_req      = req_valid && req_ready;
   assign cap_rsp      = rd_rsp_valid && rd_rsp_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PUL_IDLE;
         sent_q  <= 1'b0;
         inv_q   <= 1'b0;
      end else begin
         inv_q <= cap_req && req_bad;
         unique case (state_q)
            PUL_IDLE: begin
               sent_q <= 1'b0;
               if (cap_req && !req_bad) state_q <= PUL_WAIT_MEM;
            end
            PUL_WAIT_MEM: begin
               if (rd_req_valid && rd_req_ready) sent_q <= 1'b1;
               if (cap_rsp) begin
                  state_q <= PUL_WRITEBACK;
                  sent_q  <= 1'b0;
               end
            end
            PUL_WRITEBACK: begin
               if (wb_ready) state_q <= PUL_IDLE;
            end
            default: state_q <= PUL_IDLE;
         endcase
      end
   end

   AST_BAD_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_bad) |=> (inv_pulse && !rd_req_valid && !wb_valid && req_ready)); // R6
   AST_INV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (inv_pulse && !$past(req_valid && req_ready && req_bad)) |-> 1'b0); // R6
   AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && !req_bad) |=> !req_ready); // R7
   AST_BUSY_UNTIL_WB: assert property (@(posedge clk) disable iff (rst)
      (!req_ready && !(wb_valid && wb_ready)) |=> !req_ready); // R7
   AST_RDREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_req_valid && !rd_req_ready) |=> rd_req_valid); // R8
   AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !wb_ready) |=> wb_valid); // R8
   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!rd_req_valid && !wb_valid && !inv_pulse && req_ready)); // R9
endmodule

// File: rtl/pul_wb_fmt.sv
module pul_wb_fmt #(
   parameter int DATA_W         = 64,
   parameter int WORD_W         = 32,
   parameter bit WORD_FILL_ONES = 1'b0
) (
   input  logic              wb_valid,
   input  logic              dword,
   input  logic [DATA_W-1:0] rd_data,
   output logic              fpr_valid,
   output logic [DATA_W-1:0] fpr_data,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_data
);
   localparam int FILL_W = DATA_W - WORD_W;

   if (WORD_W < 8 || WORD_W >= DATA_W) begin : g_bad_word
      $error("pul_wb_fmt: WORD_W must be in 8..DATA_W-1");
   end

   assign fpr_valid  = wb_valid && dword;
   assign word_valid = wb_valid && !dword;
   assign fpr_data   = rd_data;

   // placeholder widening of a word ahead of format conversion
   if (WORD_FILL_ONES) begin : g_fill_ones
      assign word_data = {{FILL_W{1'b1}}, rd_data[WORD_W-1:0]};
   end else begin : g_fill_zero
      assign word_data = {{FILL_W{1'b0}}, rd_data[WORD_W-1:0]};
   end
endmodule

// File: rtl/pul_load_agu.sv
module pul_load_agu #(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int SH_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_index,
   input  logic [SH_W-1:0]   req_shift,
   input  logic              req_base_is_zero,
   input  logic              req_dword,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [ADDR_W-1:0] rd_req_addr,
   output logic              rd_req_dword,
   input  logic              rd_rsp_valid,
   output logic              rd_rsp_ready,
   input  logic [DATA_W-1:0] rd_rsp_data,
   output logic              wb_valid,
   input  logic              wb_ready,
   output logic              wb_fpr_valid,
   output logic [DATA_W-1:0] wb_fpr_data,
   output logic              wb_word_valid,
   output logic [DATA_W-1:0] wb_word_data,
   output logic              wb_base_valid,
   output logic [ADDR_W-1:0] wb_base_data,
   output logic              inv_pulse
);
   localparam int WORD_W = DATA_W / 2;

   if (DATA_W != 64) begin : g_bad_data
      $error("pul_load_agu: DATA_W must be 64");
   end

   logic              cap_req, cap_rsp;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] base_q, sum_q;
   logic              dword_q;
   logic [DATA_W-1:0] data_q;

   pul_ea_gen #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_ea (
      .base (req_base),
      .index(req_index),
      .shift(req_shift),
      .sum  (sum)
   );

   pul_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .req_valid   (req_valid),
      .req_bad     (req_base_is_zero),
      .req_ready   (req_ready),
      .rd_req_valid(rd_req_valid),
      .rd_req_ready(rd_req_ready),
      .rd_rsp_valid(rd_rsp_valid),
      .rd_rsp_ready(rd_rsp_ready),
      .wb_valid    (wb_valid),
      .wb_ready    (wb_ready),
      .inv_pulse   (inv_pulse),
      .cap_req     (cap_req),
      .cap_rsp     (cap_rsp)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q  <= '0;
         sum_q   <= '0;
         dword_q <= 1'b0;
         data_q  <= '0;
      end else begin
         if (cap_req && !req_base_is_zero) begin
            base_q  <= req_base;
            sum_q   <= sum;
            dword_q <= req_dword;
         end
         if (cap_rsp) data_q <= rd_rsp_data;
      end
   end

   assign rd_req_addr   = base_q;
   assign rd_req_dword  = dword_q;
   assign wb_base_valid = wb_valid;
   assign wb_base_data  = sum_q;

   pul_wb_fmt #(.DATA_W(DATA_W), .WORD_W(WORD_W), .WORD_FILL_ONES(1'b0)) u_fmt (
      .wb_valid  (wb_valid),
      .dword     (dword_q),
      .rd_data   (data_q),
      .fpr_valid (wb_fpr_valid),
      .fpr_data  (wb_fpr_data),
      .word_valid(wb_word_valid),
      .word_data (wb_word_data)
   );

   AST_WB_PAIRED: assert property (@(posedge clk) disable iff (rst)
      (wb_base_valid || wb_fpr_valid || wb_word_valid) |->
      (wb_base_valid && $onehot({wb_fpr_valid, wb_word_valid}))); // R5
   AST_RDADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
      (rd_req_valid && !rd_req_ready) |=> ($stable(rd_req_addr) && $stable(rd_req_dword))); // R8
   AST_WBDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
      (wb_valid && !wb_ready) |=> ($stable(wb_base_data) && $stable(wb_fpr_data)
                                   && $stable(wb_word_data))); // R8
   AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      wb_word_valid |-> (wb_word_data[DATA_W-1:WORD_W] == '0)); // R3
endmodule

// File: tb/pul_load_agu_tb.sv
module pul_load_agu_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_base_is_zero = 1'b0, req_dword = 1'b0;
   logic [63:0] req_base = '0, req_index = '0;
   logic [1:0]  req_shift = '0;
   logic        rd_req_ready = 1'b0, rd_rsp_valid = 1'b0, wb_ready = 1'b0;
   logic [63:0] rd_rsp_data = '0;
   logic        req_ready, rd_req_valid, rd_req_dword, rd_rsp_ready, wb_valid;
   logic        wb_fpr_valid, wb_word_valid, wb_base_valid, inv_pulse;
   logic [63:0] rd_req_addr, wb_fpr_data, wb_word_data, wb_base_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   pul_load_agu u_dut (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
      .req_index(req_index), .req_shift(req_shift),
      .req_base_is_zero(req_base_is_zero), .req_dword(req_dword),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_req_addr(rd_req_addr), .rd_req_dword(rd_req_dword),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
      .rd_rsp_data(rd_rsp_data),
      .wb_valid(wb_valid), .wb_ready(wb_ready),
      .wb_fpr_valid(wb_fpr_valid), .wb_fpr_data(wb_fpr_data),
      .wb_word_valid(wb_word_valid), .wb_word_data(wb_word_data),
      .wb_base_valid(wb_base_valid), .wb_base_data(wb_base_data),
      .inv_pulse(inv_pulse)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [63:0] b, input logic [63:0] ix, input logic [1:0] sh,
                          input logic dw, input logic [63:0] md, input int rstall,
                          input int wstall);
      logic [63:0] exp_sum;
      exp_sum = b + (ix << (int'(sh) + 1));
      @(negedge clk);
      chk("R7 idle ready", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_base = b; req_index = ix; req_shift = sh;
      req_dword = dw; req_base_is_zero = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 busy after accept", {63'd0, req_ready}, 64'd0);
      for (int i = 0; i < rstall; i++) begin
         @(negedge clk);
      end
      chk("R8 rd_req held", {63'd0, rd_req_valid}, 64'd1);
      chk("R2 read address is old base", rd_req_addr, b);
      chk(dw ? "R4 read size" : "R3 read size", {63'd0, rd_req_dword}, {63'd0, dw});
      rd_req_ready = 1'b1;
      @(negedge clk);
      rd_req_ready = 1'b0;
      rd_rsp_valid = 1'b1; rd_rsp_data = md;
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      for (int i = 0; i < wstall; i++) begin
         @(negedge clk);
      end
      chk("R7 busy in writeback", {63'd0, req_ready}, 64'd0);
      chk("R5 base strobe", {63'd0, wb_base_valid}, 64'd1);
      chk("R1 base update value", wb_base_data, exp_sum);
      if (dw) begin
         chk("R4 fpr strobe", {62'd0, wb_fpr_valid, wb_word_valid}, 64'd2);
         chk("R4 fpr data", wb_fpr_data, md);
      end else begin
         chk("R3 word strobe", {62'd0, wb_fpr_valid, wb_word_valid}, 64'd1);
         chk("R3 word data", wb_word_data, {32'd0, md[31:0]});
      end
      wb_ready = 1'b1;
      @(negedge clk);
      wb_ready = 1'b0;
      chk("R7 idle after writeback", {62'd0, req_ready, wb_valid}, 64'd2);
   endtask

   task automatic do_bad(input logic [63:0] b, input logic dw);
      @(negedge clk);
      req_valid = 1'b1; req_base = b; req_index = 64'h10; req_shift = 2'd1;
      req_dword = dw; req_base_is_zero = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_base_is_zero = 1'b0;
      chk("R6 invalid pulse", {60'd0, inv_pulse, rd_req_valid, wb_valid, req_ready}, 64'h9);
      @(negedge clk);
      chk("R6 pulse one cycle, no traffic", {60'd0, inv_pulse, rd_req_valid, wb_valid, req_ready}, 64'h1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [63:0] bases [6];
      logic [63:0] idxs [6];
      bases[0] = 64'h0000_0000_0000_1000; idxs[0] = 64'h0;
      bases[1] = 64'h0000_0000_0000_2000; idxs[1] = 64'h1;
      bases[2] = 64'h1234_5678_9ABC_DEF0; idxs[2] = 64'h0000_0000_0000_0123;
      bases[3] = 64'hFFFF_FFFF_FFFF_FFF0; idxs[3] = 64'h8;
      bases[4] = 64'h0000_0000_0000_0040; idxs[4] = 64'hFFFF_FFFF_FFFF_FFFF;
      bases[5] = 64'h8000_0000_0000_0000; idxs[5] = 64'hC000_0000_0000_0001;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R9 reset state", {60'd0, req_ready, rd_req_valid, wb_valid, inv_pulse}, 64'h8);
      for (int sh = 0; sh < 4; sh++) begin
         for (int dw = 0; dw < 2; dw++) begin
            for (int p = 0; p < 6; p++) begin
               do_load(bases[p], idxs[p], 2'(sh), dw[0],
                       64'hA5C3_0F96_5A3C_F069 ^ (64'(sh * 16 + dw * 8 + p) * 64'h0101_0101_0101_0101),
                       p % 3, (p + sh) % 3);
            end
         end
      end
      do_bad(64'h1000, 1'b0);
      do_bad(64'h2000, 1'b1);
      do_load(64'h3000, 64'h4, 2'd3, 1'b1, 64'hDEAD_BEEF_0123_4567, 1, 1);
      // reset in mid-flight: R9
      @(negedge clk);
      req_valid = 1'b1; req_base = 64'h40; req_index = 64'h2; req_shift = 2'd0;
      req_dword = 1'b0; req_base_is_zero = 1'b0;
      @(negedge clk);
      req_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R9 reset mid-flight", {60'd0, req_ready, rd_req_valid, wb_valid, inv_pulse}, 64'h8);
      do_load(64'h50, 64'h3, 2'd2, 1'b0, 64'hFFFF_FFFF_8765_4321, 0, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule